// File: doc/BRIEF.md
# Exception Vector Address Generator

This block turns a set of pending exception request lines into one handler fetch address. Three groups of requests come in. Reset-class events are power-on, manual and debug-port reset. General exceptions are raised by instruction fetch: address error, TLB miss and TLB invalid. The last group is a single interrupt request line. In any cycle the block accepts exactly one request. A reset-class event beats everything else. Among the general exceptions a fixed order of occurrence decides. An interrupt is taken only when nothing else is pending.

Reset-class events always jump to the absolute address 0xA000_0000. Every other event adds an offset to a base register that software loads. A TLB miss uses offset 0x400, the other general exceptions use 0x100, and an interrupt uses 0x600. The address, a one-hot code naming the accepted event and a valid strobe are all registered. They appear in the cycle after the requests are sampled.

Top module: `exc_vector_gen`

## Requirements
- R1: When any bit of `rst_req` is sampled at a clock edge, `vec_addr` equals 0xA000_0000 after that edge, whatever the base register holds.
- R2: When the winning general exception is the TLB miss (`gen_req` bit 1), `vec_addr` equals base + 0x400.
- R3: When the winning general exception is the address error (`gen_req` bit 0) or the TLB invalid (`gen_req` bit 2), `vec_addr` equals base + 0x100.
- R4: When only `irq_req` is pending, `vec_addr` equals base + 0x600.
- R5: A pending reset-class event wins over any general exception or interrupt in the same cycle.
- R6: Among general exceptions, bit 0 (address error) wins over bit 1 (TLB miss), and bit 1 wins over bit 2 (TLB invalid). Any general exception wins over `irq_req`.
- R7: `vec_code` is one-hot while valid. Bit 0 is power-on, bit 1 manual reset, bit 2 debug reset, bits 3 to 5 are `gen_req` bits 0 to 2, and bit 6 is the interrupt. When several reset sources are active together, the code names the highest-indexed one.
- R8: `vec_valid` is 1 in the cycle after any request is sampled and 0 otherwise. While it is 0, `vec_code` is zero and `vec_addr` keeps its last value.
- R9: The base register changes only on a clock edge with `vbr_we` high, and takes `vbr_wdata`. A request sampled at that same edge uses the old base. `rst_n` low clears the base to zero.
- R10: The base-plus-offset sum is 32 bits wide and wraps on overflow.
- R11: While `rst_n` is low, `vec_valid`, `vec_code` and `vec_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the block |
| vbr_we | input | 1 | Base register write enable |
| vbr_wdata | input | 32 | Base register write data |
| rst_req | input | 3 | Reset-class requests: bit 0 power-on, bit 1 manual, bit 2 debug |
| gen_req | input | 3 | General exceptions: bit 0 address error, bit 1 TLB miss, bit 2 TLB invalid |
| irq_req | input | 1 | Interrupt request |
| vec_valid | output | 1 | Accepted-event strobe |
| vec_addr | output | 32 | Handler fetch address |
| vec_code | output | 7 | One-hot accepted-event code |

## Verification
Every result is due exactly one clock edge after the requests are sampled. The same holds for a base register write, which reaches the next request's address one edge after `vbr_we` is sampled. The bench therefore drives inputs just after an edge and updates its model at the next rising edge, using the base value it held before that edge's write. It then compares the outputs one nanosecond later. A request given in the same cycle as a write is checked against the old base. A request given in the cycle after the write is checked against the new base.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RESET,
        CLS_TLB,
        CLS_GEN,
        CLS_IRQ
    } vec_cls_e;

endpackage

// File: rtl/exc_vbr_reg.sv
module exc_vbr_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] vbr_q
);

    logic [ADDR_W-1:0] vbr_d;

    always_comb begin
        vbr_d = vbr_q;
        if (we) begin
            vbr_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbr_q <= '0;
        end else begin
            vbr_q <= vbr_d;
        end
    end

endmodule

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_vec_pkg::*;
#(
    parameter int NUM_RST      = 3,
    parameter int NUM_GEN      = 3,
    parameter int TLB_MISS_IDX = 1,
    localparam int CODE_W      = NUM_RST + NUM_GEN + 1
) (
    input  logic [NUM_RST-1:0] rst_req,
    input  logic [NUM_GEN-1:0] gen_req,
    input  logic               irq_req,
    output vec_cls_e           cls,
    output logic [CODE_W-1:0]  code
);

    logic [NUM_RST-1:0] rst_oh;
    logic [NUM_GEN-1:0] gen_oh;

    // Reset sources: ascending scan, so the highest active index is kept.
    always_comb begin
        rst_oh = '0;
        for (int i = 0; i < NUM_RST; i++) begin
            if (rst_req[i]) begin
                rst_oh    = '0;
                rst_oh[i] = 1'b1;
            end
        end
    end

    // General exceptions: descending scan, so the lowest index (earliest) is kept.
    always_comb begin
        gen_oh = '0;
        for (int i = NUM_GEN - 1; i >= 0; i--) begin
            if (gen_req[i]) begin
                gen_oh    = '0;
                gen_oh[i] = 1'b1;
            end
        end
    end

    always_comb begin
        cls  = CLS_NONE;
        code = '0;
        if (|rst_req) begin
            cls                    = CLS_RESET;
            code[NUM_RST-1:0]      = rst_oh;
        end else if (|gen_req) begin
            cls                    = gen_oh[TLB_MISS_IDX] ? CLS_TLB : CLS_GEN;
            code[NUM_RST +: NUM_GEN] = gen_oh;
        end else if (irq_req) begin
            cls                    = CLS_IRQ;
            code[CODE_W-1]         = 1'b1;
        end
    end

endmodule

// File: rtl/exc_addr_form.sv
module exc_addr_form
    import exc_vec_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] OFF_GEN   = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] OFF_TLB   = 32'h0000_0400,
    parameter logic [ADDR_W-1:0] OFF_IRQ   = 32'h0000_0600
) (
    input  vec_cls_e          cls,
    input  logic [ADDR_W-1:0] vbr,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        case (cls)
            CLS_TLB: offset = OFF_TLB;
            CLS_GEN: offset = OFF_GEN;
            CLS_IRQ: offset = OFF_IRQ;
            default: offset = '0;
        endcase
    end

    // Sum kept at ADDR_W bits: carry out is dropped, address wraps.
    always_comb begin
        if (cls == CLS_RESET) begin
            addr = RESET_VEC;
        end else begin
            addr = vbr + offset;
        end
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_vec_pkg::*;
#(
    parameter int              ADDR_W       = 32,
    parameter int              NUM_RST      = 3,
    parameter int              NUM_GEN      = 3,
    parameter int              TLB_MISS_IDX = 1,
    parameter logic [ADDR_W-1:0] RESET_VEC  = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] OFF_GEN    = 32'h0000_0100,
    parameter logic [ADDR_W-1:0] OFF_TLB    = 32'h0000_0400,
    parameter logic [ADDR_W-1:0] OFF_IRQ    = 32'h0000_0600
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         vbr_we,
    input  logic [ADDR_W-1:0]            vbr_wdata,
    input  logic [NUM_RST-1:0]           rst_req,
    input  logic [NUM_GEN-1:0]           gen_req,
    input  logic                         irq_req,
    output logic                         vec_valid,
    output logic [ADDR_W-1:0]            vec_addr,
    output logic [NUM_RST+NUM_GEN:0]     vec_code
);

    localparam int CODE_W = NUM_RST + NUM_GEN + 1;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CODE_W-1:0] code;
    } out_st_t;

    out_st_t           st_d, st_q;
    logic [ADDR_W-1:0] vbr_q;
    vec_cls_e          sel_cls;
    logic [CODE_W-1:0] sel_code;
    logic [ADDR_W-1:0] sel_addr;

    exc_vbr_reg #(
        .ADDR_W (ADDR_W)
    ) u_vbr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (vbr_we),
        .wdata  (vbr_wdata),
        .vbr_q  (vbr_q)
    );

    exc_prio_sel #(
        .NUM_RST      (NUM_RST),
        .NUM_GEN      (NUM_GEN),
        .TLB_MISS_IDX (TLB_MISS_IDX)
    ) u_sel (
        .rst_req (rst_req),
        .gen_req (gen_req),
        .irq_req (irq_req),
        .cls     (sel_cls),
        .code    (sel_code)
    );

    exc_addr_form #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC),
        .OFF_GEN   (OFF_GEN),
        .OFF_TLB   (OFF_TLB),
        .OFF_IRQ   (OFF_IRQ)
    ) u_addr (
        .cls  (sel_cls),
        .vbr  (vbr_q),
        .addr (sel_addr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = (sel_cls != CLS_NONE);
        st_d.code  = sel_code;
        if (sel_cls != CLS_NONE) begin
            st_d.addr = sel_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_valid = st_q.valid;
    assign vec_addr  = st_q.addr;
    assign vec_code  = st_q.code;

endmodule

// File: rtl/exc_vector_gen_chk.sv
module exc_vector_gen_chk #(
    parameter int              ADDR_W    = 32,
    parameter int              NUM_RST   = 3,
    parameter int              NUM_GEN   = 3,
    parameter logic [ADDR_W-1:0] RESET_VEC = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] OFF_IRQ   = 32'h0000_0600
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     vbr_we,
    input logic [ADDR_W-1:0]        vbr_wdata,
    input logic [ADDR_W-1:0]        vbr_q,
    input logic [NUM_RST-1:0]       rst_req,
    input logic [NUM_GEN-1:0]       gen_req,
    input logic                     irq_req,
    input logic                     vec_valid,
    input logic [ADDR_W-1:0]        vec_addr,
    input logic [NUM_RST+NUM_GEN:0] vec_code
);

    logic any_req;
    logic irq_only;
    assign any_req  = (|rst_req) || (|gen_req) || irq_req;
    assign irq_only = irq_req && !(|rst_req) && !(|gen_req);

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> vec_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> (!vec_valid && vec_code == '0)); // R8
    AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_req |=> $stable(vec_addr)); // R8
    AST_CODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ($countones(vec_code) == 1)); // R7
    AST_RESET_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_req) |=> (vec_addr == RESET_VEC && (|vec_code[NUM_RST-1:0]))); // R5
    AST_IRQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_only |=> (vec_addr == $past(vbr_q) + OFF_IRQ)); // R4
    AST_VBR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !vbr_we |=> $stable(vbr_q)); // R9
    AST_VBR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        vbr_we |=> (vbr_q == $past(vbr_wdata))); // R9

endmodule

bind exc_vector_gen exc_vector_gen_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_RST   (NUM_RST),
    .NUM_GEN   (NUM_GEN),
    .RESET_VEC (RESET_VEC),
    .OFF_IRQ   (OFF_IRQ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vbr_we    (vbr_we),
    .vbr_wdata (vbr_wdata),
    .vbr_q     (vbr_q),
    .rst_req   (rst_req),
    .gen_req   (gen_req),
    .irq_req   (irq_req),
    .vec_valid (vec_valid),
    .vec_addr  (vec_addr),
    .vec_code  (vec_code)
);

// File: tb/exc_vector_gen_bench.sv
module exc_vector_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vbr_we = 1'b0;
    logic [31:0] vbr_wdata = '0;
    logic [2:0]  rst_req = '0;
    logic [2:0]  gen_req = '0;
    logic        irq_req = 1'b0;
    logic        vec_valid;
    logic [31:0] vec_addr;
    logic [6:0]  vec_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_vbr = '0;
    logic [31:0] e_addr = '0;
    logic [6:0]  e_code = '0;
    logic        e_valid = 1'b0;

    always #2 clk = ~clk;

    exc_vector_gen u_exc_vector_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .vbr_we    (vbr_we),
        .vbr_wdata (vbr_wdata),
        .rst_req   (rst_req),
        .gen_req   (gen_req),
        .irq_req   (irq_req),
        .vec_valid (vec_valid),
        .vec_addr  (vec_addr),
        .vec_code  (vec_code)
    );

    function automatic string tag_of(logic [2:0] r, logic [2:0] g, logic i);
        if (|r && (|g || i))           return "R5";
        if (|r && $countones(r) > 1)   return "R7";
        if (|r)                        return "R1";
        if (|g && ($countones(g) > 1 || i)) return "R6";
        if (g[0] || g[2])              return (g[1] ? "R6" : "R3");
        if (g[1])                      return "R2";
        if (i)                         return "R4";
        return "R8";
    endfunction

    // Model: compute the expected outputs for the edge just taken.
    task automatic model_edge();
        e_valid = (|rst_req) || (|gen_req) || irq_req;
        e_code  = '0;
        if (|rst_req) begin
            e_addr = 32'hA000_0000;
            for (int k = 0; k < 3; k++) if (rst_req[k]) begin e_code = '0; e_code[k] = 1'b1; end
        end else if (|gen_req) begin
            for (int k = 2; k >= 0; k--) if (gen_req[k]) begin e_code = '0; e_code[3+k] = 1'b1; end
            e_addr = m_vbr + (e_code[4] ? 32'h400 : 32'h100);
        end else if (irq_req) begin
            e_code[6] = 1'b1;
            e_addr = m_vbr + 32'h600;
        end
        if (vbr_we) m_vbr = vbr_wdata;
    endtask

    task automatic check(string tag);
        checks++;
        if (vec_valid !== e_valid || vec_addr !== e_addr || vec_code !== e_code) begin
            failures++;
            $display("FAIL %s: got valid=%0b addr=%h code=%b, expected valid=%0b addr=%h code=%b",
                     tag, vec_valid, vec_addr, vec_code, e_valid, e_addr, e_code);
        end
    endtask

    // Apply inputs, take one edge, check one time unit after it.
    task automatic step(logic [2:0] r, logic [2:0] g, logic i, logic we, logic [31:0] wd, string tag);
        rst_req = r; gen_req = g; irq_req = i; vbr_we = we; vbr_wdata = wd;
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs cleared while in reset
        e_valid = 1'b0; e_addr = '0; e_code = '0;
        check("R11");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R9: base cleared by reset -> interrupt uses offset alone
        step(3'b000, 3'b000, 1'b1, 1'b0, '0, "R9");
        // R9: write and request in the same cycle use the old base
        step(3'b000, 3'b000, 1'b1, 1'b1, 32'h8000_1000, "R9");
        step(3'b000, 3'b010, 1'b0, 1'b0, '0, "R2");
        step(3'b000, 3'b100, 1'b0, 1'b0, '0, "R3");
        step(3'b000, 3'b110, 1'b1, 1'b0, '0, "R6");
        step(3'b000, 3'b000, 1'b0, 1'b0, '0, "R8");
        step(3'b111, 3'b111, 1'b1, 1'b0, '0, "R7");
        step(3'b011, 3'b000, 1'b0, 1'b0, '0, "R7");
        step(3'b001, 3'b001, 1'b1, 1'b0, '0, "R5");
        // R10: sum wraps past 32 bits
        step(3'b000, 3'b000, 1'b0, 1'b1, 32'hFFFF_FF00, "R9");
        step(3'b000, 3'b000, 1'b1, 1'b0, '0, "R10");
        step(3'b000, 3'b010, 1'b0, 1'b0, '0, "R10");
        step(3'b000, 3'b000, 1'b0, 1'b0, '0, "R8");

        for (int n = 0; n < 3000; n++) begin
            logic [2:0]  r, g;
            logic        i, we;
            logic [31:0] wd;
            r  = ($urandom % 8 == 0) ? 3'($urandom) : 3'b000;
            g  = ($urandom % 2 == 0) ? 3'($urandom) : 3'b000;
            i  = 1'($urandom % 3 == 0);
            we = 1'($urandom % 5 == 0);
            wd = (n % 97 == 0) ? 32'hFFFF_FFF0 : $urandom;
            step(r, g, i, we, wd, tag_of(r, g, i));
        end

        // R9 and R11: mid-run reset clears outputs and base
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        e_valid = 1'b0; e_addr = '0; e_code = '0; m_vbr = '0;
        check("R11");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        step(3'b000, 3'b001, 1'b0, 1'b0, '0, "R9");
        step(3'b000, 3'b000, 1'b0, 1'b0, '0, "R8");

        finish_run();
    end

endmodule